// File: doc/BRIEF.md
# BCD Time and Calendar Counter

This block keeps wall-clock time and the calendar as a chain of packed-BCD counters: seconds, minutes, hours in 24-hour form, day of week, date, month, two-digit year and a two-digit century. A free-running enable at the oscillator rate (nominally 32768 Hz) feeds a binary prescaler. The prescaler makes a one-second tick that steps the seconds counter, and each counter carries into the next one when it wraps. One bit of the same prescaler gives a square-wave test output (512 Hz at the default setting).

A register file outside this block owns the host bus. When software finishes setting the time, the register file pulses `load` for one cycle with the new values and the stop flag. The load replaces every counter and restarts the prescaler. The block picks the last day of each month on its own. February gets a 29th day in any year whose BCD value is a multiple of four, and this includes year 00. While the stop flag is set, the prescaler and all counters hold their values.

Top module: `bcd_rtc_chain`

## Requirements
- R1: After reset the counters hold seconds 00, minutes 00, hours 00, day of week 1, date 01, month 01, year 00 and century 00. The stop flag is 0 and the test output is 0.
- R2: While running, the seconds counter steps once for every 2^PRE_W cycles in which `osc_en` is high. The new value appears after the clock edge that samples the final enable of that group. Cycles with `osc_en` low do not count.
- R3: Seconds and minutes wrap from 59 to 00 and carry into the next counter. Hours wrap from 23 to 00 and carry into the day.
- R4: On a day carry, the date advances and the day of week advances at the same time. The day of week wraps from 7 to 1.
- R5: The date wraps to 01 and carries into the month after day 30 in months 04, 06, 09 and 11, and after day 31 in months 01, 03, 05, 07, 08, 10 and 12.
- R6: In month 02 the date wraps after day 29 when the BCD year is divisible by four (00 included), and after day 28 otherwise.
- R7: The month wraps from 12 to 01 and advances the year. The year wraps from 99 to 00 and advances the century. The century wraps from 39 to 00.
- R8: While the stop flag is 1, the prescaler and every counter hold, and the test output stays 0.
- R9: While running, the test output equals prescaler bit TAP_BIT. After a load it reads 0, rises after 2^TAP_BIT counted enables and falls after 2^(TAP_BIT+1).
- R10: A `load` pulse replaces all counters and the stop flag with the load inputs and clears the prescaler. The first tick after it comes a full 2^PRE_W counted enables later.
- R11: An out-of-range value keeps counting. The ones digit increments modulo 16, a ones digit of 9 carries into the tens digit modulo its width, and a carry to the next counter happens only when the value equals that counter's last legal value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_en | input | 1 | Oscillator-rate enable, one cycle per oscillator period |
| load | input | 1 | Parallel load strobe |
| ld_stop | input | 1 | Stop flag to load |
| ld_sec | input | 7 | Seconds to load, BCD |
| ld_min | input | 7 | Minutes to load, BCD |
| ld_hour | input | 6 | Hours to load, BCD |
| ld_wday | input | 3 | Day of week to load, 1..7 |
| ld_date | input | 6 | Date to load, BCD |
| ld_month | input | 5 | Month to load, BCD |
| ld_year | input | 8 | Year to load, BCD |
| ld_cent | input | 6 | Century to load, BCD |
| stop_o | output | 1 | Current stop flag |
| sec_o | output | 7 | Seconds, BCD |
| min_o | output | 7 | Minutes, BCD |
| hour_o | output | 6 | Hours, BCD |
| wday_o | output | 3 | Day of week |
| date_o | output | 6 | Date, BCD |
| month_o | output | 5 | Month, BCD |
| year_o | output | 8 | Year, BCD |
| cent_o | output | 6 | Century, BCD |
| sq_o | output | 1 | Square-wave test output |

## Verification
Calendar rollovers such as end of February, end of year and century wrap take years of ticks to reach by counting. The stimulus gets there through the parallel load: it places the chain one to three seconds before the boundary and then lets the prescaler run. The prescaler is shrunk to 16 enables per second, so each of these cases costs only tens of cycles. The same load path places deliberately out-of-range values to show that they keep counting and do not carry.

// File: rtl/bcd_rtc_pkg.sv
package bcd_rtc_pkg;

  // A BCD year is a multiple of four when an even tens digit meets a ones
  // digit of 0/4/8, or an odd tens digit meets 2/6.
  function automatic logic year_is_leap(input logic [7:0] yr);
    logic [3:0] ones;
    ones = yr[3:0];
    if (!yr[4]) return (ones == 4'd0) || (ones == 4'd4) || (ones == 4'd8);
    else        return (ones == 4'd2) || (ones == 4'd6);
  endfunction

  // Last legal date of a month, packed BCD.
  function automatic logic [5:0] month_last_day(input logic [4:0] mon,
                                                input logic [7:0] yr);
    case (mon)
      5'h02:                      return year_is_leap(yr) ? 6'h29 : 6'h28;
      5'h04, 5'h06, 5'h09, 5'h11: return 6'h30;
      default:                    return 6'h31;
    endcase
  endfunction

endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int PRE_W   = 15,
  parameter int TAP_BIT = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic osc_en,
  input  logic run,
  input  logic clear,
  output logic tick,
  output logic tap
);
  logic [PRE_W-1:0] cnt_q, cnt_d;
  logic             adv;

  assign adv  = osc_en && run && !clear;
  assign tick = adv && (&cnt_q);
  assign tap  = run && cnt_q[TAP_BIT];

  always_comb begin
    cnt_d = cnt_q;
    if (clear)    cnt_d = '0;
    else if (adv) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  a_r10_clear_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (cnt_q == '0));
  a_r2_tick_wraps: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (cnt_q == '0));
  a_r8_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !clear) |=> $stable(cnt_q));
endmodule

// File: rtl/rtc_bcd_field.sv
module rtc_bcd_field #(
  parameter int                  TENS_W  = 3,
  parameter logic [TENS_W+3:0]   RST_VAL = '0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                inc,
  input  logic                load,
  input  logic [TENS_W+3:0]   ld_val,
  input  logic [TENS_W+3:0]   last_val,
  input  logic [TENS_W+3:0]   first_val,
  output logic [TENS_W+3:0]   value,
  output logic                carry
);
  localparam int W = TENS_W + 4;

  logic [W-1:0]      val_q, val_d;
  logic [TENS_W-1:0] tens;
  logic [3:0]        ones;
  logic              at_last;

  assign tens    = val_q[W-1:4];
  assign ones    = val_q[3:0];
  assign at_last = (val_q == last_val);
  assign carry   = inc && !load && at_last;
  assign value   = val_q;

  always_comb begin
    val_d = val_q;
    if (load)                val_d = ld_val;
    else if (inc) begin
      if (at_last)           val_d = first_val;
      else if (ones == 4'd9) val_d = {tens + 1'b1, 4'h0};
      else                   val_d = {tens, ones + 4'd1};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) val_q <= RST_VAL;
    else        val_q <= val_d;
  end

  a_r11_always_moves: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !load) |=> (val_q != $past(val_q)));
  a_r8_holds_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!inc && !load) |=> $stable(val_q));
  a_r3_wraps_to_first: assert property (@(posedge clk) disable iff (!rst_n)
    carry |=> (val_q == $past(first_val)));
endmodule

// File: rtl/rtc_wday.sv
module rtc_wday (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       inc,
  input  logic       load,
  input  logic [2:0] ld_val,
  output logic [2:0] value
);
  logic [2:0] wd_q, wd_d;

  assign value = wd_q;

  always_comb begin
    wd_d = wd_q;
    if (load)     wd_d = ld_val;
    else if (inc) wd_d = (wd_q == 3'd7) ? 3'd1 : wd_q + 3'd1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wd_q <= 3'd1;
    else        wd_q <= wd_d;
  end

  a_r4_wday_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !load && wd_q == 3'd7) |=> (wd_q == 3'd1));
endmodule

// File: rtl/bcd_rtc_chain.sv
module bcd_rtc_chain
  import bcd_rtc_pkg::*;
#(
  parameter int PRE_W   = 15,
  parameter int TAP_BIT = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       osc_en,
  input  logic       load,
  input  logic       ld_stop,
  input  logic [6:0] ld_sec,
  input  logic [6:0] ld_min,
  input  logic [5:0] ld_hour,
  input  logic [2:0] ld_wday,
  input  logic [5:0] ld_date,
  input  logic [4:0] ld_month,
  input  logic [7:0] ld_year,
  input  logic [5:0] ld_cent,
  output logic       stop_o,
  output logic [6:0] sec_o,
  output logic [6:0] min_o,
  output logic [5:0] hour_o,
  output logic [2:0] wday_o,
  output logic [5:0] date_o,
  output logic [4:0] month_o,
  output logic [7:0] year_o,
  output logic [5:0] cent_o,
  output logic       sq_o
);
  logic stop_q, stop_d;
  logic tick;
  logic c_sec, c_min, c_hour, c_date, c_month, c_year, c_cent;
  logic [5:0] date_last;

  always_comb begin
    stop_d = stop_q;
    if (load) stop_d = ld_stop;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stop_q <= 1'b0;
    else        stop_q <= stop_d;
  end

  assign stop_o    = stop_q;
  assign date_last = month_last_day(month_o, year_o);

  rtc_prescaler #(.PRE_W(PRE_W), .TAP_BIT(TAP_BIT)) u_pre (
    .clk(clk), .rst_n(rst_n), .osc_en(osc_en), .run(!stop_q),
    .clear(load), .tick(tick), .tap(sq_o));

  rtc_bcd_field #(.TENS_W(3), .RST_VAL(7'h00)) u_sec (
    .clk(clk), .rst_n(rst_n), .inc(tick), .load(load), .ld_val(ld_sec),
    .last_val(7'h59), .first_val(7'h00), .value(sec_o), .carry(c_sec));

  rtc_bcd_field #(.TENS_W(3), .RST_VAL(7'h00)) u_min (
    .clk(clk), .rst_n(rst_n), .inc(c_sec), .load(load), .ld_val(ld_min),
    .last_val(7'h59), .first_val(7'h00), .value(min_o), .carry(c_min));

  rtc_bcd_field #(.TENS_W(2), .RST_VAL(6'h00)) u_hour (
    .clk(clk), .rst_n(rst_n), .inc(c_min), .load(load), .ld_val(ld_hour),
    .last_val(6'h23), .first_val(6'h00), .value(hour_o), .carry(c_hour));

  rtc_wday u_wday (
    .clk(clk), .rst_n(rst_n), .inc(c_hour), .load(load), .ld_val(ld_wday),
    .value(wday_o));

  rtc_bcd_field #(.TENS_W(2), .RST_VAL(6'h01)) u_date (
    .clk(clk), .rst_n(rst_n), .inc(c_hour), .load(load), .ld_val(ld_date),
    .last_val(date_last), .first_val(6'h01), .value(date_o), .carry(c_date));

  rtc_bcd_field #(.TENS_W(1), .RST_VAL(5'h01)) u_month (
    .clk(clk), .rst_n(rst_n), .inc(c_date), .load(load), .ld_val(ld_month),
    .last_val(5'h12), .first_val(5'h01), .value(month_o), .carry(c_month));

  rtc_bcd_field #(.TENS_W(4), .RST_VAL(8'h00)) u_year (
    .clk(clk), .rst_n(rst_n), .inc(c_month), .load(load), .ld_val(ld_year),
    .last_val(8'h99), .first_val(8'h00), .value(year_o), .carry(c_year));

  rtc_bcd_field #(.TENS_W(2), .RST_VAL(6'h00)) u_cent (
    .clk(clk), .rst_n(rst_n), .inc(c_year), .load(load), .ld_val(ld_cent),
    .last_val(6'h39), .first_val(6'h00), .value(cent_o), .carry(c_cent));

  a_r8_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_q && !load) |=> ($stable(sec_o) && $stable(min_o) && $stable(hour_o)
                           && $stable(date_o) && $stable(year_o)));
  a_r8_quiet_tap: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_q && !load) |=> !sq_o);
  a_r4_date_follows_day: assert property (@(posedge clk) disable iff (!rst_n)
    c_hour |=> (date_o != $past(date_o)) && (wday_o != $past(wday_o)));
  a_r7_century_step: assert property (@(posedge clk) disable iff (!rst_n)
    c_year |=> (year_o == 8'h00) && (cent_o != $past(cent_o)));
  a_r7_century_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    c_cent |=> (cent_o == 6'h00));
endmodule

// File: tb/tb_bcd_rtc_chain.sv
`timescale 1ns/1ps
module tb_bcd_rtc_chain;
  localparam int PRE_W   = 4;
  localparam int TAP_BIT = 1;
  localparam int SEC_CYC = 1 << PRE_W;

  typedef struct packed {
    logic [5:0] cent;
    logic [7:0] year;
    logic [4:0] month;
    logic [5:0] date;
    logic [2:0] wday;
    logic [5:0] hour;
    logic [6:0] min;
    logic [6:0] sec;
  } tm_t;

  typedef struct packed {
    logic [3:0] secs;
    tm_t        start;
    tm_t        want;
  } vec_t;

  localparam int NV = 21;
  localparam vec_t VEC [NV] = '{
    '{4'd1, '{6'h20,8'h24,5'h03,6'h15,3'd2,6'h00,7'h00,7'h00}, '{6'h20,8'h24,5'h03,6'h15,3'd2,6'h00,7'h00,7'h01}}, // R2
    '{4'd3, '{6'h20,8'h24,5'h03,6'h15,3'd2,6'h00,7'h00,7'h58}, '{6'h20,8'h24,5'h03,6'h15,3'd2,6'h00,7'h01,7'h01}}, // R2 R3
    '{4'd1, '{6'h20,8'h24,5'h03,6'h15,3'd2,6'h12,7'h34,7'h59}, '{6'h20,8'h24,5'h03,6'h15,3'd2,6'h12,7'h35,7'h00}}, // R3
    '{4'd1, '{6'h20,8'h24,5'h03,6'h15,3'd2,6'h12,7'h59,7'h59}, '{6'h20,8'h24,5'h03,6'h15,3'd2,6'h13,7'h00,7'h00}}, // R3
    '{4'd1, '{6'h20,8'h24,5'h03,6'h15,3'd7,6'h23,7'h59,7'h59}, '{6'h20,8'h24,5'h03,6'h16,3'd1,6'h00,7'h00,7'h00}}, // R4
    '{4'd1, '{6'h20,8'h24,5'h04,6'h30,3'd3,6'h23,7'h59,7'h59}, '{6'h20,8'h24,5'h05,6'h01,3'd4,6'h00,7'h00,7'h00}}, // R5
    '{4'd1, '{6'h20,8'h24,5'h01,6'h31,3'd3,6'h23,7'h59,7'h59}, '{6'h20,8'h24,5'h02,6'h01,3'd4,6'h00,7'h00,7'h00}}, // R5
    '{4'd1, '{6'h20,8'h24,5'h11,6'h30,3'd5,6'h23,7'h59,7'h59}, '{6'h20,8'h24,5'h12,6'h01,3'd6,6'h00,7'h00,7'h00}}, // R5
    '{4'd1, '{6'h20,8'h24,5'h08,6'h30,3'd5,6'h23,7'h59,7'h59}, '{6'h20,8'h24,5'h08,6'h31,3'd6,6'h00,7'h00,7'h00}}, // R5
    '{4'd1, '{6'h20,8'h23,5'h02,6'h28,3'd1,6'h23,7'h59,7'h59}, '{6'h20,8'h23,5'h03,6'h01,3'd2,6'h00,7'h00,7'h00}}, // R6
    '{4'd1, '{6'h20,8'h24,5'h02,6'h28,3'd1,6'h23,7'h59,7'h59}, '{6'h20,8'h24,5'h02,6'h29,3'd2,6'h00,7'h00,7'h00}}, // R6
    '{4'd1, '{6'h20,8'h24,5'h02,6'h29,3'd2,6'h23,7'h59,7'h59}, '{6'h20,8'h24,5'h03,6'h01,3'd3,6'h00,7'h00,7'h00}}, // R6
    '{4'd1, '{6'h21,8'h00,5'h02,6'h28,3'd4,6'h23,7'h59,7'h59}, '{6'h21,8'h00,5'h02,6'h29,3'd5,6'h00,7'h00,7'h00}}, // R6
    '{4'd1, '{6'h19,8'h96,5'h02,6'h28,3'd4,6'h23,7'h59,7'h59}, '{6'h19,8'h96,5'h02,6'h29,3'd5,6'h00,7'h00,7'h00}}, // R6
    '{4'd1, '{6'h20,8'h02,5'h02,6'h28,3'd4,6'h23,7'h59,7'h59}, '{6'h20,8'h02,5'h03,6'h01,3'd5,6'h00,7'h00,7'h00}}, // R6
    '{4'd1, '{6'h19,8'h99,5'h12,6'h31,3'd6,6'h23,7'h59,7'h59}, '{6'h20,8'h00,5'h01,6'h01,3'd7,6'h00,7'h00,7'h00}}, // R7
    '{4'd1, '{6'h39,8'h99,5'h12,6'h31,3'd6,6'h23,7'h59,7'h59}, '{6'h00,8'h00,5'h01,6'h01,3'd7,6'h00,7'h00,7'h00}}, // R7
    '{4'd1, '{6'h20,8'h41,5'h12,6'h31,3'd7,6'h23,7'h59,7'h59}, '{6'h20,8'h42,5'h01,6'h01,3'd1,6'h00,7'h00,7'h00}}, // R7
    '{4'd1, '{6'h20,8'h24,5'h03,6'h10,3'd2,6'h29,7'h59,7'h59}, '{6'h20,8'h24,5'h03,6'h10,3'd2,6'h30,7'h00,7'h00}}, // R11
    '{4'd1, '{6'h20,8'h24,5'h03,6'h10,3'd2,6'h05,7'h10,7'h7A}, '{6'h20,8'h24,5'h03,6'h10,3'd2,6'h05,7'h10,7'h7B}}, // R11
    '{4'd1, '{6'h20,8'h23,5'h02,6'h30,3'd2,6'h23,7'h59,7'h59}, '{6'h20,8'h23,5'h02,6'h31,3'd3,6'h00,7'h00,7'h00}}  // R11
  };

  logic clk = 1'b0;
  logic rst_n, osc_en, load, ld_stop;
  tm_t  ld;
  logic stop_o, sq_o;
  tm_t  cur;
  int   n_chk = 0;
  int   n_bad = 0;

  always #2.5 clk = ~clk;

  bcd_rtc_chain #(.PRE_W(PRE_W), .TAP_BIT(TAP_BIT)) dut (
    .clk(clk), .rst_n(rst_n), .osc_en(osc_en), .load(load), .ld_stop(ld_stop),
    .ld_sec(ld.sec), .ld_min(ld.min), .ld_hour(ld.hour), .ld_wday(ld.wday),
    .ld_date(ld.date), .ld_month(ld.month), .ld_year(ld.year), .ld_cent(ld.cent),
    .stop_o(stop_o), .sec_o(cur.sec), .min_o(cur.min), .hour_o(cur.hour),
    .wday_o(cur.wday), .date_o(cur.date), .month_o(cur.month), .year_o(cur.year),
    .cent_o(cur.cent), .sq_o(sq_o));

  task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic do_load(input tm_t t, input logic stp);
    @(negedge clk);
    ld = t; ld_stop = stp; load = 1'b1;
    @(posedge clk);
    @(negedge clk);
    load = 1'b0;
  endtask

  task automatic wait_edges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    tm_t base;
    rst_n = 1'b0; osc_en = 1'b0; load = 1'b0; ld_stop = 1'b0; ld = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset values
    check("R1", 64'(cur), 64'(tm_t'{6'h00,8'h00,5'h01,6'h01,3'd1,6'h00,7'h00,7'h00}));
    check("R1", {62'd0, stop_o, sq_o}, 64'd0);
    rst_n = 1'b1;
    osc_en = 1'b1;

    // Table walk: R2 R3 R4 R5 R6 R7 R11
    for (int i = 0; i < NV; i++) begin
      do_load(VEC[i].start, 1'b0);
      wait_edges(SEC_CYC * int'(VEC[i].secs));
      check($sformatf("vector %0d", i), 64'(cur), 64'(VEC[i].want));
    end

    base = '{6'h20,8'h24,5'h06,6'h12,3'd3,6'h10,7'h20,7'h30};

    // R2: exact tick edge
    do_load(base, 1'b0);
    wait_edges(SEC_CYC - 1);
    check("R2 before tick", 64'(cur.sec), 64'(7'h30));
    wait_edges(1);
    check("R2 on tick", 64'(cur.sec), 64'(7'h31));

    // R2: idle enables do not count
    do_load(base, 1'b0);
    wait_edges(SEC_CYC - 2);
    osc_en = 1'b0;
    wait_edges(40);
    check("R2 idle osc", 64'(cur.sec), 64'(7'h30));
    osc_en = 1'b1;
    wait_edges(2);
    check("R2 resumed", 64'(cur.sec), 64'(7'h31));

    // R9: test output shape
    do_load(base, 1'b0);
    check("R9 after load", {63'd0, sq_o}, 64'd0);
    wait_edges(1 << TAP_BIT);
    check("R9 rise", {63'd0, sq_o}, 64'd1);
    wait_edges(1 << TAP_BIT);
    check("R9 fall", {63'd0, sq_o}, 64'd0);

    // R8: stop flag freezes everything
    do_load(base, 1'b1);
    check("R8 stop flag", {63'd0, stop_o}, 64'd1);
    wait_edges(3 * SEC_CYC);
    check("R8 frozen", 64'(cur), 64'(base));
    check("R8 tap low", {63'd0, sq_o}, 64'd0);
    do_load(base, 1'b0);
    wait_edges(SEC_CYC);
    check("R8 restart", 64'(cur.sec), 64'(7'h31));

    // R10: reload mid-second restarts the prescaler
    do_load(base, 1'b0);
    wait_edges(SEC_CYC - 4);
    base.sec = 7'h45;
    do_load(base, 1'b0);
    wait_edges(SEC_CYC - 1);
    check("R10 no early tick", 64'(cur.sec), 64'(7'h45));
    wait_edges(1);
    check("R10 full second", 64'(cur.sec), 64'(7'h46));

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule